// File: doc/BRIEF.md
# Multi-Channel Memory/Peripheral DMA Engine

This block is a memory-mapped DMA controller with a parameterised number of channels. Software programs each channel through its own register window with a source address, a destination address, an address-stepping mode for each side and a byte count, then launches one or more channels at once through a shared command register. The same command register, with its top bit set, stops the selected channels.

An active channel moves data one 32-bit word per beat over a simple request/acknowledge bus: each beat is a read from the source side followed by a write to the destination side. The byte count falls as data is written and can be read back at any time as the residue; a final beat shorter than a word is written with byte enables. Each channel keeps two sticky events, completion and abort, visible both on output pins and in a status register that software clears by writing ones. An abort raises the completion event as well, and takes effect on the clock edge that accepts the command, so software can poll for it.

When several channels are active, the bus is handed out again before every beat to the lowest-numbered active channel.

Top module: `dmx_engine`

## Requirements
- R1: A register write to offset 0x000 with bit 31 clear starts every channel whose bit is set in the low NUM_CH bits (one or several at once); a started channel with a non-zero size reports busy in bit 2 of its status register from the next cycle.
- R2: Each beat is a read of the word at the source address followed by a write of that word to the destination address; `bus_req`, `bus_we`, `bus_addr`, `bus_be` and `bus_wdata` hold steady from request until `bus_ack`.
- R3: Channel n's window starts at 0x100 + 0x40*n. The mode registers (source 0x20, destination 0x24) keep the mode in bits [5:4]: 0 steps the address by +4 after each beat, 1 by -4, 2 or 3 leaves it fixed; the address registers (source 0x28, destination 0x2C) read back the stepped value.
- R4: The size register (0x30) reads the number of bytes not yet written and drops by 4 after each full-word write.
- R5: When fewer than 4 bytes remain, the last write drives `bus_be` with only the low n bits set ((1<<n)-1), leaves the other destination bytes unchanged, and the size reaches 0.
- R6: When the size reaches 0 the channel leaves busy and its completion event (status bit 0, `evt_done[n]`) is set; a start with size 0 sets the completion event at once with no bus traffic.
- R7: A write to 0x000 with bit 31 set clears busy of every selected channel on the next cycle and sets both its completion and its abort event (status bit 1, `evt_abort[n]`), also for an idle channel; a read already on the bus for an aborted channel is finished but its write is never issued.
- R8: A start to a busy channel, and a write to any of its mode, address or size registers while busy, have no effect.
- R9: Before each beat, the lowest-numbered busy channel is granted the bus.
- R10: Writing ones to the status register (0x10) clears the completion (bit 0) and abort (bit 1) events.
- R11: After reset all channels are idle with zeroed registers, no events and no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address (writes and reads) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bus_req | output | 1 | Data bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Data bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte enables of a write |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer accepted |
| evt_done | output | NUM_CH | Sticky completion event per channel |
| evt_abort | output | NUM_CH | Sticky abort event per channel |

## Verification
The hardest case to reach is an abort that lands while the channel's read is still waiting on the bus, since a fast bus finishes the beat before the register write can arrive. The bench holds back the acknowledge from its memory model, starts the channel, lets the read request sit stalled, issues the abort, then releases the bus and confirms that no write appears. The same stall is used to freeze a channel in busy so that residue, ignored restarts and ignored configuration writes can be observed at the ports.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    parameter int DW = 32;

    localparam logic [5:0] OFF_STAT  = 6'h10;
    localparam logic [5:0] OFF_SMODE = 6'h20;
    localparam logic [5:0] OFF_DMODE = 6'h24;
    localparam logic [5:0] OFF_SADDR = 6'h28;
    localparam logic [5:0] OFF_DADDR = 6'h2C;
    localparam logic [5:0] OFF_SIZE  = 6'h30;

    typedef enum logic [1:0] {
        MD_INC = 2'd0,
        MD_DEC = 2'd1,
        MD_FIX = 2'd2
    } step_mode_e;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_RD   = 2'd1,
        MV_WR   = 2'd2
    } mv_state_e;

    typedef struct packed {
        logic          busy;
        logic [1:0]    smode;
        logic [1:0]    dmode;
        logic [DW-1:0] saddr;
        logic [DW-1:0] daddr;
        logic [DW-1:0] size;
        logic          ev_done;
        logic          ev_abort;
    } chan_regs_t;

    function automatic logic [DW-1:0] step_addr(input logic [DW-1:0] a, input logic [1:0] m);
        case (m)
            MD_INC:  step_addr = a + DW'(4);
            MD_DEC:  step_addr = a - DW'(4);
            default: step_addr = a;
        endcase
    endfunction

    function automatic logic [3:0] tail_be(input logic [DW-1:0] sz);
        if (sz >= DW'(4))      tail_be = 4'hF;
        else if (sz == DW'(3)) tail_be = 4'h7;
        else if (sz == DW'(2)) tail_be = 4'h3;
        else if (sz == DW'(1)) tail_be = 4'h1;
        else                   tail_be = 4'h0;
    endfunction

endpackage

// File: rtl/dmx_chan.sv
module dmx_chan
    import dmx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [5:0]    cfg_off,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          cmd_start,
    input  logic          cmd_abort,
    input  logic          beat_done,
    output chan_regs_t    st
);

    chan_regs_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (cfg_we && cfg_off == OFF_STAT) begin
            if (cfg_wdata[0]) ch_d.ev_done  = 1'b0;
            if (cfg_wdata[1]) ch_d.ev_abort = 1'b0;
        end
        if (cfg_we && !ch_q.busy) begin
            case (cfg_off)
                OFF_SMODE: ch_d.smode = cfg_wdata[5:4];
                OFF_DMODE: ch_d.dmode = cfg_wdata[5:4];
                OFF_SADDR: ch_d.saddr = cfg_wdata;
                OFF_DADDR: ch_d.daddr = cfg_wdata;
                OFF_SIZE:  ch_d.size  = cfg_wdata;
                default:   ;
            endcase
        end
        if (beat_done && ch_q.busy) begin
            ch_d.saddr = step_addr(ch_q.saddr, ch_q.smode);
            ch_d.daddr = step_addr(ch_q.daddr, ch_q.dmode);
            if (ch_q.size <= DW'(4)) begin
                ch_d.size    = '0;
                ch_d.busy    = 1'b0;
                ch_d.ev_done = 1'b1;
            end else begin
                ch_d.size = ch_q.size - DW'(4);
            end
        end
        if (cmd_start && !ch_q.busy) begin
            if (ch_q.size == '0) ch_d.ev_done = 1'b1;
            else                 ch_d.busy    = 1'b1;
        end
        if (cmd_abort) begin
            ch_d.busy     = 1'b0;
            ch_d.ev_done  = 1'b1;
            ch_d.ev_abort = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign st = ch_q;

endmodule

// File: rtl/dmx_prio.sv
module dmx_prio #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic [IDX_W-1:0]  pick,
    output logic              any
);

    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) pick = IDX_W'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/dmx_mover.sv
module dmx_mover
    import dmx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] busy,
    input  logic              any_busy,
    input  logic [IDX_W-1:0]  pick,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [IDX_W-1:0]  gnt_idx,
    input  logic [DW-1:0]     sel_saddr,
    input  logic [DW-1:0]     sel_daddr,
    input  logic [DW-1:0]     sel_size,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic [3:0]        bus_be,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic [NUM_CH-1:0] beat_done
);

    typedef struct packed {
        mv_state_e      st;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]  src;
        logic [DW-1:0]  dst;
        logic [DW-1:0]  data;
        logic [3:0]     be;
    } mv_t;

    mv_t mv_d, mv_q;

    always_comb begin
        mv_d = mv_q;
        case (mv_q.st)
            MV_IDLE: begin
                if (any_busy) begin
                    mv_d.st  = MV_RD;
                    mv_d.idx = pick;
                    mv_d.src = sel_saddr;
                    mv_d.dst = sel_daddr;
                    mv_d.be  = tail_be(sel_size);
                end
            end
            MV_RD: begin
                if (bus_ack) begin
                    mv_d.data = bus_rdata;
                    mv_d.st   = busy[mv_q.idx] ? MV_WR : MV_IDLE;
                end
            end
            MV_WR: begin
                if (bus_ack) mv_d.st = MV_IDLE;
            end
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mv_q <= '0;
        else        mv_q <= mv_d;
    end

    assign cur_idx   = (mv_q.st == MV_IDLE) ? pick : mv_q.idx;
    assign gnt_idx   = mv_q.idx;
    assign bus_req   = (mv_q.st != MV_IDLE);
    assign bus_we    = (mv_q.st == MV_WR);
    assign bus_addr  = (mv_q.st == MV_WR) ? mv_q.dst : mv_q.src;
    assign bus_wdata = mv_q.data;
    assign bus_be    = (mv_q.st == MV_WR) ? mv_q.be : 4'hF;
    assign beat_done = (mv_q.st == MV_WR && bus_ack) ? (NUM_CH'(1) << mv_q.idx) : '0;

endmodule

// File: rtl/dmx_engine.sv
module dmx_engine
    import dmx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic [3:0]        bus_be,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic [NUM_CH-1:0] evt_done,
    output logic [NUM_CH-1:0] evt_abort
);

    localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BLK_W    = REG_AW - 6;
    localparam int WIN_BLK0 = 'h100 / 'h40;
    localparam int ABORT_B  = DW - 1;

    chan_regs_t          ch_st [NUM_CH];
    logic [NUM_CH-1:0]   ch_busy;
    logic [NUM_CH-1:0]   beat_done;
    logic [NUM_CH-1:0]   start_vec, abort_vec;
    logic [BLK_W-1:0]    blk;
    logic [IDX_W-1:0]    win_idx, pick, cur_idx, gnt_idx;
    logic                in_win, is_cmd, any_busy;
    chan_regs_t          sel_ch, rd_ch;

    assign is_cmd    = (reg_addr == '0);
    assign blk       = reg_addr[REG_AW-1:6] - BLK_W'(WIN_BLK0);
    assign in_win    = (reg_addr[REG_AW-1:6] >= BLK_W'(WIN_BLK0)) && (blk < BLK_W'(NUM_CH));
    assign win_idx   = blk[IDX_W-1:0];
    assign start_vec = (reg_wr && is_cmd && !reg_wdata[ABORT_B]) ? reg_wdata[NUM_CH-1:0] : '0;
    assign abort_vec = (reg_wr && is_cmd &&  reg_wdata[ABORT_B]) ? reg_wdata[NUM_CH-1:0] : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dmx_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (reg_wr && in_win && win_idx == IDX_W'(g)),
            .cfg_off   (reg_addr[5:0]),
            .cfg_wdata (reg_wdata),
            .cmd_start (start_vec[g]),
            .cmd_abort (abort_vec[g]),
            .beat_done (beat_done[g]),
            .st        (ch_st[g])
        );
        assign ch_busy[g]   = ch_st[g].busy;
        assign evt_done[g]  = ch_st[g].ev_done;
        assign evt_abort[g] = ch_st[g].ev_abort;
    end

    dmx_prio #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_prio (
        .req  (ch_busy),
        .pick (pick),
        .any  (any_busy)
    );

    assign sel_ch = ch_st[cur_idx];

    dmx_mover #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (ch_busy),
        .any_busy  (any_busy),
        .pick      (pick),
        .cur_idx   (cur_idx),
        .gnt_idx   (gnt_idx),
        .sel_saddr (sel_ch.saddr),
        .sel_daddr (sel_ch.daddr),
        .sel_size  (sel_ch.size),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .beat_done (beat_done)
    );

    assign rd_ch = ch_st[win_idx];

    always_comb begin
        reg_rdata = '0;
        if (in_win) begin
            case (reg_addr[5:0])
                OFF_STAT:  reg_rdata = {{(DW-3){1'b0}}, rd_ch.busy, rd_ch.ev_abort, rd_ch.ev_done};
                OFF_SMODE: reg_rdata = {{(DW-6){1'b0}}, rd_ch.smode, 4'h0};
                OFF_DMODE: reg_rdata = {{(DW-6){1'b0}}, rd_ch.dmode, 4'h0};
                OFF_SADDR: reg_rdata = rd_ch.saddr;
                OFF_DADDR: reg_rdata = rd_ch.daddr;
                OFF_SIZE:  reg_rdata = rd_ch.size;
                default:   reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmx_engine_chk.sv
module dmx_engine_chk #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2,
    parameter int REG_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [31:0]       bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [3:0]        bus_be,
    input logic [NUM_CH-1:0] evt_done,
    input logic [NUM_CH-1:0] evt_abort,
    input logic [NUM_CH-1:0] ch_busy,
    input logic [IDX_W-1:0]  gnt_idx
);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr)
                                && $stable(bus_be) && $stable(bus_wdata));

    assert_write_has_bytes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_be != 4'h0);

    assert_lowest_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (($past(ch_busy) & ((NUM_CH'(1) << gnt_idx) - NUM_CH'(1))) == '0));

    assert_idle_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(ch_busy) != '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ev
        assert_abort_brings_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_abort[i]) |-> evt_done[i]);

        assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr && reg_addr == '0 && reg_wdata[31] && reg_wdata[i]
            |=> !ch_busy[i] && evt_abort[i] && evt_done[i]);

        assert_finish_flags_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_busy[i]) |-> evt_done[i]);
    end

endmodule

bind dmx_engine dmx_engine_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .evt_done  (evt_done),
    .evt_abort (evt_abort),
    .ch_busy   (ch_busy),
    .gnt_idx   (gnt_idx)
);

// File: tb/dmx_engine_bench.sv
module dmx_engine_bench;

    localparam int NCH = 4;
    localparam int AW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          bus_req, bus_we;
    logic [31:0]   bus_addr, bus_wdata;
    logic [3:0]    bus_be;
    logic [31:0]   rd_r = '0;
    logic          ack_r = 1'b0;
    logic [NCH-1:0] evt_done, evt_abort;

    logic          stall = 1'b0;
    logic [31:0]   mem [512];
    logic [31:0]   log_addr [64];
    logic [31:0]   log_data [64];
    logic [3:0]    log_be [64];
    int            log_n = 0;
    int            n_chk = 0;
    int            n_fail = 0;

    always #2 clk = ~clk;

    dmx_engine #(.NUM_CH(NCH), .REG_AW(AW)) u_dmx_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_rdata(rd_r), .bus_ack(ack_r),
        .evt_done(evt_done), .evt_abort(evt_abort)
    );

    // memory model: one-cycle acknowledge, held back while stall is set
    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0;
        end else if (bus_req && !ack_r && !stall) begin
            ack_r <= 1'b1;
            if (bus_we) begin
                for (int b = 0; b < 4; b++)
                    if (bus_be[b]) mem[bus_addr[10:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
                log_addr[log_n[5:0]] <= bus_addr;
                log_data[log_n[5:0]] <= bus_wdata;
                log_be[log_n[5:0]]   <= bus_be;
                log_n <= log_n + 1;
            end else begin
                rd_r <= mem[bus_addr[10:2]];
            end
        end else begin
            ack_r <= 1'b0;
        end
    end

    function automatic logic [AW-1:0] cha(input int ch, input int off);
        return AW'(32'h100 + ch * 32'h40 + off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic setup(input int ch, input int sm, input int dm,
                         input logic [31:0] sa, input logic [31:0] da, input logic [31:0] sz);
        wr(cha(ch, 'h10), 32'h3);
        wr(cha(ch, 'h20), 32'(sm) << 4);
        wr(cha(ch, 'h24), 32'(dm) << 4);
        wr(cha(ch, 'h28), sa);
        wr(cha(ch, 'h2C), da);
        wr(cha(ch, 'h30), sz);
    endtask

    task automatic wait_done(input int ch);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (evt_done[ch]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(cha(0, 'h10), v); chk("R11 status after reset", v, 0);
        rd(cha(2, 'h30), v); chk("R11 size after reset", v, 0);
        chk("R11 no bus request", {31'b0, bus_req}, 0);
        chk("R11 no events", {24'b0, evt_done, evt_abort}, 0);
    endtask

    task automatic t_mem_to_dev();
        logic [31:0] v;
        int base;
        for (int i = 0; i < 4; i++) mem[64 + i] = 32'hA000_0000 + 32'(i * 17);
        setup(0, 0, 2, 32'h100, 32'h300, 16);
        stall = 1'b1;
        base = log_n;
        wr(12'h000, 32'h1);
        rd(cha(0, 'h10), v); chk("R1 busy after start", v, 32'h4);
        rd(cha(0, 'h30), v); chk("R4 residue before first write", v, 16);
        stall = 1'b0;
        wait_done(0);
        chk("R2 four writes", 32'(log_n - base), 4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 fixed destination address", log_addr[base + i], 32'h300);
            chk("R2 word order from incrementing source", log_data[base + i], 32'hA000_0000 + 32'(i * 17));
        end
        rd(cha(0, 'h30), v); chk("R4 size ends at zero", v, 0);
        rd(cha(0, 'h10), v); chk("R6 done and idle", v, 32'h1);
        rd(cha(0, 'h28), v); chk("R3 source stepped up", v, 32'h110);
        rd(cha(0, 'h2C), v); chk("R3 fixed destination unchanged", v, 32'h300);
    endtask

    task automatic t_dev_to_mem_dec();
        logic [31:0] v;
        mem['h20C >> 2] = 32'h1111_0003;
        mem['h208 >> 2] = 32'h1111_0002;
        mem['h204 >> 2] = 32'h1111_0001;
        setup(0, 1, 0, 32'h20C, 32'h400, 12);
        wr(12'h000, 32'h1);
        wait_done(0);
        chk("R3 decrement word 0", mem['h400 >> 2], 32'h1111_0003);
        chk("R3 decrement word 1", mem['h404 >> 2], 32'h1111_0002);
        chk("R3 decrement word 2", mem['h408 >> 2], 32'h1111_0001);
        rd(cha(0, 'h28), v); chk("R3 source stepped down", v, 32'h200);
        rd(cha(0, 'h2C), v); chk("R3 destination stepped up", v, 32'h40C);
        rd(cha(0, 'h20), v); chk("R3 mode readback bits 5:4", v, 32'h10);
    endtask

    task automatic t_partial();
        logic [31:0] v;
        int base;
        mem['h140 >> 2] = 32'hCAFE_0001;
        mem['h144 >> 2] = 32'hBEEF_5A5A;
        mem['h440 >> 2] = 32'h0;
        mem['h444 >> 2] = 32'h7777_7777;
        setup(3, 0, 0, 32'h140, 32'h440, 6);
        base = log_n;
        wr(12'h000, 32'h8);
        wait_done(3);
        chk("R5 two writes", 32'(log_n - base), 2);
        chk("R5 full first beat", {28'b0, log_be[base]}, 32'hF);
        chk("R5 two-byte tail enables", {28'b0, log_be[base + 1]}, 32'h3);
        chk("R5 tail merges low bytes only", mem['h444 >> 2], 32'h7777_5A5A);
        rd(cha(3, 'h30), v); chk("R5 size zero after tail", v, 0);
    endtask

    task automatic t_zero_size();
        logic [31:0] v;
        int base;
        setup(2, 0, 0, 32'h100, 32'h480, 0);
        base = log_n;
        wr(12'h000, 32'h4);
        rd(cha(2, 'h10), v); chk("R6 zero size completes at once", v, 32'h1);
        repeat (8) @(negedge clk);
        chk("R6 zero size makes no writes", 32'(log_n - base), 0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int base;
        setup(1, 0, 0, 32'h100, 32'h480, 16);
        stall = 1'b1;
        base = log_n;
        wr(12'h000, 32'h2);
        repeat (3) @(negedge clk);
        chk("R7 read pending before abort", {31'b0, bus_req}, 1);
        wr(12'h000, 32'h8000_0002);
        rd(cha(1, 'h10), v); chk("R7 abort stops and flags both events", v, 32'h3);
        chk("R7 abort event pin", {28'b0, evt_abort}, 32'h2);
        stall = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 no write after aborted read", 32'(log_n - base), 0);
        chk("R7 bus idle after abort", {31'b0, bus_req}, 0);
        wr(cha(2, 'h10), 32'h3);
        wr(12'h000, 32'h8000_0004);
        rd(cha(2, 'h10), v); chk("R7 abort of idle channel", v, 32'h3);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(cha(1, 'h10), 32'h2);
        rd(cha(1, 'h10), v); chk("R10 clear abort only", v, 32'h1);
        wr(cha(1, 'h10), 32'h1);
        rd(cha(1, 'h10), v); chk("R10 clear done", v, 32'h0);
        chk("R10 event pins cleared", {31'b0, evt_done[1]}, 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int base;
        setup(0, 0, 0, 32'h100, 32'h4A0, 8);
        stall = 1'b1;
        base = log_n;
        wr(12'h000, 32'h1);
        wr(cha(0, 'h30), 32'd100);
        wr(cha(0, 'h2C), 32'h000);
        wr(12'h000, 32'h1);
        rd(cha(0, 'h30), v); chk("R8 size write ignored while busy", v, 8);
        rd(cha(0, 'h2C), v); chk("R8 address write ignored while busy", v, 32'h4A0);
        stall = 1'b0;
        wait_done(0);
        repeat (6) @(negedge clk);
        chk("R8 restart did not add beats", 32'(log_n - base), 2);
        chk("R8 original destination used", log_addr[base], 32'h4A0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        int base;
        setup(1, 0, 0, 32'h100, 32'h500, 8);
        setup(2, 0, 0, 32'h100, 32'h540, 4);
        stall = 1'b1;
        base = log_n;
        wr(12'h000, 32'h6);
        rd(cha(1, 'h10), v); chk("R1 multi-hot start ch1", v, 32'h4);
        rd(cha(2, 'h10), v); chk("R1 multi-hot start ch2", v, 32'h4);
        stall = 1'b0;
        wait_done(2);
        wait_done(1);
        chk("R9 three writes", 32'(log_n - base), 3);
        chk("R9 first beat to ch1", log_addr[base], 32'h500);
        chk("R9 second beat to ch1", log_addr[base + 1], 32'h504);
        chk("R9 ch2 after ch1 drains", log_addr[base + 2], 32'h540);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mem_to_dev();
        t_dev_to_mem_dec();
        t_partial();
        t_zero_size();
        t_abort();
        t_w1c();
        t_busy_ignore();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule